// File: doc/BRIEF.md
# Bundle Register-Write Commit Unit

This block collects the register writes produced by one execution bundle and applies them together when the bundle retires. Each 32-bit write names a target in a small register space and carries a bit mask and a value; only the masked bits of the target change. A separate queue holds whole-word writes to the 64-bit accumulators. On a commit pulse the unit applies the 32-bit writes in the order they were queued, then the accumulator writes, then an optional trap transformation of the status word. Both queues are empty afterwards.

Two writes in the same bundle may touch the arithmetic flag bits of the status word. The unit resolves that conflict so that the later write wins. A write to the overflow flag also shields the accumulated-overflow flag from the earlier write. The arbitration is skipped when the issuing side reports that the first unit's instruction cancels the second. After the commit, a one-cycle request tells the stack-bank logic to re-check which stack pointer is active.

Top module: `bundle_commit`

## Requirements
- R1: A committed 32-bit write changes its target to (old & ~mask) | (value & mask). Here old is the target's value after all earlier writes of the same bundle.
- R2: The 32-bit writes apply in queue order, so a later write to the same register overrides the earlier one on the bits they share. Accumulator writes replace the whole 64-bit word, and a later one to the same accumulator wins.
- R3: The status word is register 13. Its flag bits are F0=11, F1=10, F2=9, F3=8, S=4, V=3, VA=2 and C=0, giving the mask 0x0000_0F1D. An earlier status write loses the flag bits that a later status write in the bundle also covers, and keeps its other bits.
- R4: Suppose a later status write overlaps an earlier one on at least one flag bit and its mask includes V (bit 3). Then the earlier write's VA bit (bit 2) is not applied, even when the later mask omits VA.
- R5: While lkr_i is high at the commit, no flag arbitration takes place and every write applies with its full mask in queue order.
- R6: trap_i = 1 is an ordinary trap. After the writes, register 14 receives the status word, and the status word keeps only SM (bit 31) and DB (bit 29).
- R7: trap_i = 2 is a debug trap. After the writes, register 15 receives the status word, and the status word becomes DS only (bit 28, 0x1000_0000). A trap_i value of 0 or 3 causes no trap.
- R8: swap_req_o is high for exactly the one cycle after a commit that contained a write targeting register 13, whatever its mask, or a trap. It stays low after any other commit.
- R9: A commit empties both queues, so a following commit with no new entries changes no state. An enqueue beyond four 32-bit or two 64-bit entries is dropped. An enqueue in the same cycle as a commit is dropped.
- R10: After reset, all registers and accumulators read zero and swap_req_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq32_i | input | 1 | Queue a 32-bit masked write |
| enq32_idx_i | input | 4 | Target register index |
| enq32_mask_i | input | 32 | Bit mask of the write |
| enq32_val_i | input | 32 | Value of the write |
| enq64_i | input | 1 | Queue an accumulator write |
| enq64_idx_i | input | 1 | Target accumulator |
| enq64_val_i | input | 64 | Accumulator value |
| commit_i | input | 1 | Apply the queued writes |
| lkr_i | input | 1 | First unit kills second: bypass flag arbitration |
| trap_i | input | 2 | 0 none, 1 ordinary trap, 2 debug trap, 3 none |
| rd_idx_i | input | 4 | Register read index |
| rd_data_o | output | 32 | Register read data |
| acc_idx_i | input | 1 | Accumulator read index |
| acc_data_o | output | 64 | Accumulator read data |
| psw_o | output | 32 | Current status word |
| swap_req_o | output | 1 | Stack-bank re-check request |

## Verification
A wrong effective mask in the arbiter shows in the status word at the read port straight after the commit edge. The VA case separates arbitration from plain ordered writes, because only there do the two give different results. A queue counter that fails to clear shows up one commit later, when an empty commit changes a register or raises swap_req_o. A trap miscoded as the other kind leaves its saved copy in the wrong register, which can be read back in the same cycle.

// File: rtl/commit_pkg.sv
package commit_pkg;
  localparam int XLEN = 32;
  localparam int ALEN = 64;

  localparam int SM_B = 31;
  localparam int DB_B = 29;
  localparam int DS_B = 28;
  localparam int F0_B = 11;
  localparam int F1_B = 10;
  localparam int F2_B = 9;
  localparam int F3_B = 8;
  localparam int S_B  = 4;
  localparam int V_B  = 3;
  localparam int VA_B = 2;
  localparam int C_B  = 0;

  localparam logic [XLEN-1:0] FLAG_MASK =
    (32'h1 << F0_B) | (32'h1 << F1_B) | (32'h1 << F2_B) | (32'h1 << F3_B) |
    (32'h1 << S_B)  | (32'h1 << V_B)  | (32'h1 << VA_B) | (32'h1 << C_B);
  localparam logic [XLEN-1:0] ORD_KEEP = (32'h1 << SM_B) | (32'h1 << DB_B);
  localparam logic [XLEN-1:0] DS_ONLY  = (32'h1 << DS_B);

  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_ORD  = 2'd1,
    TRAP_DBG  = 2'd2,
    TRAP_RSV  = 2'd3
  } trap_e;
endpackage

// File: rtl/cm_wqueue.sv
module cm_wqueue #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enq_i,
  input  logic [W-1:0]              data_i,
  input  logic                      clr_i,
  output logic [DEPTH-1:0]          valid_o,
  output logic [DEPTH-1:0][W-1:0]   data_o
);
  logic [CW-1:0]            cnt_q;
  logic [DEPTH-1:0][W-1:0]  mem_q;
  logic                     full;

  assign full = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mem_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (enq_i && !full) begin
      mem_q[cnt_q] <= data_i;
      cnt_q        <= cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_valid
    assign valid_o[k] = (CW'(k) < cnt_q);
  end
  assign data_o = mem_q;
endmodule

// File: rtl/cm_flag_arb.sv
module cm_flag_arb
  import commit_pkg::*;
#(
  parameter int N       = 4,
  parameter int IW      = 4,
  parameter int PSW_IDX = 13
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][IW-1:0]    idx_i,
  input  logic [N-1:0][XLEN-1:0]  mask_i,
  input  logic                    lkr_i,
  output logic [N-1:0][XLEN-1:0]  mask_o
);
  logic [N-1:0]           is_psw;
  logic [N-1:0][XLEN-1:0] mine;

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign is_psw[i] = valid_i[i] && (idx_i[i] == IW'(PSW_IDX));
    assign mine[i]   = mask_i[i] & FLAG_MASK;
  end

  always_comb begin
    mask_o = mask_i;
    if (!lkr_i) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (j > i && is_psw[i] && is_psw[j] && |(mask_i[j] & mine[i])) begin
            mask_o[i] = mask_o[i] & ~(mask_i[j] & mine[i]);
            if (mask_i[j][V_B]) mask_o[i][VA_B] = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cm_trap_xform.sv
module cm_trap_xform
  import commit_pkg::*;
(
  input  logic [1:0]      code_i,
  input  logic [XLEN-1:0] psw_i,
  input  logic [XLEN-1:0] bpsw_i,
  input  logic [XLEN-1:0] dpsw_i,
  output logic [XLEN-1:0] psw_o,
  output logic [XLEN-1:0] bpsw_o,
  output logic [XLEN-1:0] dpsw_o,
  output logic            trap_o
);
  always_comb begin
    psw_o  = psw_i;
    bpsw_o = bpsw_i;
    dpsw_o = dpsw_i;
    trap_o = 1'b0;
    unique case (trap_e'(code_i))
      TRAP_ORD: begin
        bpsw_o = psw_i;
        psw_o  = psw_i & ORD_KEEP;
        trap_o = 1'b1;
      end
      TRAP_DBG: begin
        dpsw_o = psw_i;
        psw_o  = DS_ONLY;
        trap_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bundle_commit.sv
module bundle_commit
  import commit_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int NUM_W32  = 4,
  parameter int NUM_ACC  = 2,
  parameter int NUM_W64  = 2,
  parameter int PSW_IDX  = 13,
  parameter int BPSW_IDX = 14,
  parameter int DPSW_IDX = 15,
  localparam int IW      = $clog2(NUM_REGS),
  localparam int AW      = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int E32W    = IW + 2 * XLEN,
  localparam int E64W    = AW + ALEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq32_i,
  input  logic [IW-1:0]    enq32_idx_i,
  input  logic [XLEN-1:0]  enq32_mask_i,
  input  logic [XLEN-1:0]  enq32_val_i,
  input  logic             enq64_i,
  input  logic [AW-1:0]    enq64_idx_i,
  input  logic [ALEN-1:0]  enq64_val_i,
  input  logic             commit_i,
  input  logic             lkr_i,
  input  logic [1:0]       trap_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [XLEN-1:0]  rd_data_o,
  input  logic [AW-1:0]    acc_idx_i,
  output logic [ALEN-1:0]  acc_data_o,
  output logic [XLEN-1:0]  psw_o,
  output logic             swap_req_o
);
  logic [NUM_W32-1:0]            v32;
  logic [NUM_W32-1:0][E32W-1:0]  e32;
  logic [NUM_W64-1:0]            v64;
  logic [NUM_W64-1:0][E64W-1:0]  e64;

  cm_wqueue #(.W(E32W), .DEPTH(NUM_W32)) i_q32 (
    .clk_i, .rst_ni,
    .enq_i   (enq32_i),
    .data_i  ({enq32_idx_i, enq32_mask_i, enq32_val_i}),
    .clr_i   (commit_i),
    .valid_o (v32),
    .data_o  (e32)
  );

  cm_wqueue #(.W(E64W), .DEPTH(NUM_W64)) i_q64 (
    .clk_i, .rst_ni,
    .enq_i   (enq64_i),
    .data_i  ({enq64_idx_i, enq64_val_i}),
    .clr_i   (commit_i),
    .valid_o (v64),
    .data_o  (e64)
  );

  logic [NUM_W32-1:0][IW-1:0]   w_idx;
  logic [NUM_W32-1:0][XLEN-1:0] w_mask;
  logic [NUM_W32-1:0][XLEN-1:0] w_val;
  logic [NUM_W32-1:0][XLEN-1:0] w_eff;
  logic [NUM_W64-1:0][AW-1:0]   a_idx;
  logic [NUM_W64-1:0][ALEN-1:0] a_val;

  for (genvar i = 0; i < NUM_W32; i++) begin : g_unpack32
    assign {w_idx[i], w_mask[i], w_val[i]} = e32[i];
  end
  for (genvar i = 0; i < NUM_W64; i++) begin : g_unpack64
    assign {a_idx[i], a_val[i]} = e64[i];
  end

  cm_flag_arb #(.N(NUM_W32), .IW(IW), .PSW_IDX(PSW_IDX)) i_arb (
    .valid_i (v32),
    .idx_i   (w_idx),
    .mask_i  (w_mask),
    .lkr_i   (lkr_i),
    .mask_o  (w_eff)
  );

  logic [NUM_REGS-1:0][XLEN-1:0] rf_q, rf_w, rf_n;
  logic [NUM_ACC-1:0][ALEN-1:0]  acc_q, acc_n;
  logic                          psw_hit;
  logic                          trap_hit;
  logic [XLEN-1:0]               t_psw, t_bpsw, t_dpsw;

  always_comb begin
    rf_w    = rf_q;
    psw_hit = 1'b0;
    for (int i = 0; i < NUM_W32; i++) begin
      if (v32[i]) begin
        rf_w[w_idx[i]] = (rf_w[w_idx[i]] & ~w_eff[i]) | (w_val[i] & w_eff[i]);
        if (w_idx[i] == IW'(PSW_IDX)) psw_hit = 1'b1;
      end
    end
  end

  always_comb begin
    acc_n = acc_q;
    for (int i = 0; i < NUM_W64; i++) begin
      if (v64[i]) acc_n[a_idx[i]] = a_val[i];
    end
  end

  cm_trap_xform i_trap (
    .code_i (trap_i),
    .psw_i  (rf_w[PSW_IDX]),
    .bpsw_i (rf_w[BPSW_IDX]),
    .dpsw_i (rf_w[DPSW_IDX]),
    .psw_o  (t_psw),
    .bpsw_o (t_bpsw),
    .dpsw_o (t_dpsw),
    .trap_o (trap_hit)
  );

  always_comb begin
    rf_n           = rf_w;
    rf_n[PSW_IDX]  = t_psw;
    rf_n[BPSW_IDX] = t_bpsw;
    rf_n[DPSW_IDX] = t_dpsw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_q       <= '0;
      acc_q      <= '0;
      swap_req_o <= 1'b0;
    end else begin
      swap_req_o <= commit_i && (psw_hit || trap_hit);
      if (commit_i) begin
        rf_q  <= rf_n;
        acc_q <= acc_n;
      end
    end
  end

  assign rd_data_o  = rf_q[rd_idx_i];
  assign acc_data_o = acc_q[acc_idx_i];
  assign psw_o      = rf_q[PSW_IDX];
endmodule

// File: rtl/bundle_commit_chk.sv
module bundle_commit_chk
  import commit_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            commit_i,
  input logic [1:0]      trap_i,
  input logic [XLEN-1:0] psw_o,
  input logic            swap_req_o
);
  AST_ORD_TRAP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && trap_i == 2'd1 |=> (psw_o & ~ORD_KEEP) == '0); // R6
  AST_DBG_TRAP_DS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && trap_i == 2'd2 |=> psw_o == DS_ONLY); // R7
  AST_TRAP_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && (trap_i == 2'd1 || trap_i == 2'd2) |=> swap_req_o); // R8
  AST_SWAP_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> !swap_req_o); // R8
  AST_PSW_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(psw_o)); // R9
endmodule

bind bundle_commit bundle_commit_chk i_chk (
  .clk_i, .rst_ni, .commit_i, .trap_i, .psw_o, .swap_req_o
);

// File: tb/test_bundle_commit.sv
`timescale 1ns/1ps
module test_bundle_commit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enq32_i = 0;
  logic [3:0]  enq32_idx_i = 0;
  logic [31:0] enq32_mask_i = 0, enq32_val_i = 0;
  logic        enq64_i = 0;
  logic [0:0]  enq64_idx_i = 0;
  logic [63:0] enq64_val_i = 0;
  logic        commit_i = 0, lkr_i = 0;
  logic [1:0]  trap_i = 0;
  logic [3:0]  rd_idx_i = 0;
  logic [31:0] rd_data_o;
  logic [0:0]  acc_idx_i = 0;
  logic [63:0] acc_data_o;
  logic [31:0] psw_o;
  logic        swap_req_o;

  int n_chk = 0, n_bad = 0;
  logic last_swap;

  always #2 clk_i = ~clk_i;

  bundle_commit i_bundle_commit (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    rd_idx_i = idx; #0.5; d = rd_data_o;
  endtask

  task automatic rdacc(input logic [0:0] idx, output logic [63:0] d);
    acc_idx_i = idx; #0.5; d = acc_data_o;
  endtask

  task automatic q32(input logic [3:0] idx, input logic [31:0] m, input logic [31:0] v);
    @(negedge clk_i);
    enq32_i = 1; enq32_idx_i = idx; enq32_mask_i = m; enq32_val_i = v;
    @(negedge clk_i);
    enq32_i = 0;
  endtask

  task automatic q64(input logic [0:0] idx, input logic [63:0] v);
    @(negedge clk_i);
    enq64_i = 1; enq64_idx_i = idx; enq64_val_i = v;
    @(negedge clk_i);
    enq64_i = 0;
  endtask

  task automatic do_commit(input logic lkr, input logic [1:0] tr);
    @(negedge clk_i);
    commit_i = 1; lkr_i = lkr; trap_i = tr;
    @(negedge clk_i);
    last_swap = swap_req_o;
    commit_i = 0; lkr_i = 0; trap_i = 0;
  endtask

  task automatic set_psw(input logic [31:0] v);
    q32(4'd13, 32'hFFFF_FFFF, v);
    do_commit(0, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [63:0] a;
    for (int i = 0; i < 16; i++) begin
      rd(i[3:0], d); chk("R10 reg reset", {32'h0, d}, 64'h0);
    end
    rdacc(0, a); chk("R10 acc0 reset", a, 64'h0);
    rdacc(1, a); chk("R10 acc1 reset", a, 64'h0);
    chk("R10 swap reset", {63'h0, swap_req_o}, 64'h0);
  endtask

  task automatic t_merge;
    logic [31:0] d;
    q32(4'd3, 32'hFFFF_FFFF, 32'h1234_5678);
    do_commit(0, 0);
    rd(3, d); chk("R1 full write", {32'h0, d}, 64'h1234_5678);
    q32(4'd3, 32'h0000_FF00, 32'hAABB_CCDD);
    do_commit(0, 0);
    rd(3, d); chk("R1 masked merge", {32'h0, d}, 64'h1234_CC78);
  endtask

  task automatic t_order;
    logic [31:0] d; logic [63:0] a;
    q32(4'd5, 32'h0000_FFFF, 32'h1111_1111);
    q32(4'd5, 32'h0000_00FF, 32'h2222_2222);
    q64(0, 64'hAAAA_0000_0000_0001);
    q64(0, 64'hBBBB_0000_0000_0002);
    do_commit(0, 0);
    rd(5, d); chk("R2 later write wins", {32'h0, d}, 64'h0000_1122);
    rdacc(0, a); chk("R2 acc later wins", a, 64'hBBBB_0000_0000_0002);
    rdacc(1, a); chk("R2 acc1 untouched", a, 64'h0);
  endtask

  task automatic t_flag_arb;
    set_psw(32'h0);
    q32(4'd13, 32'h0200_0F1D, 32'hFFFF_FFFF);
    q32(4'd13, 32'h0000_0100, 32'h0000_0000);
    do_commit(0, 0);
    chk("R3 later flag wins, other bits kept", {32'h0, psw_o}, 64'h0200_0E1D);
    chk("R8 swap after psw write", {63'h0, last_swap}, 64'h1);
  endtask

  task automatic t_va;
    set_psw(32'h0);
    q32(4'd13, 32'h0000_0005, 32'h0000_0005);
    q32(4'd13, 32'h0000_0009, 32'h0000_0000);
    do_commit(0, 0);
    chk("R4 V suppresses earlier VA", {32'h0, psw_o}, 64'h0);
  endtask

  task automatic t_lkr;
    set_psw(32'h0);
    q32(4'd13, 32'h0000_0005, 32'h0000_0005);
    q32(4'd13, 32'h0000_0009, 32'h0000_0000);
    do_commit(1, 0);
    chk("R5 bypass keeps earlier VA", {32'h0, psw_o}, 64'h4);
  endtask

  task automatic t_ord_trap;
    logic [31:0] d;
    set_psw(32'hFFFF_FFFF);
    do_commit(0, 2'd1);
    rd(14, d); chk("R6 saved status", {32'h0, d}, 64'hFFFF_FFFF);
    chk("R6 status masked", {32'h0, psw_o}, 64'hA000_0000);
    chk("R8 swap on trap", {63'h0, last_swap}, 64'h1);
    q32(4'd13, 32'h0000_00FF, 32'h0000_0012);
    do_commit(0, 2'd1);
    rd(14, d); chk("R6 save after writes", {32'h0, d}, 64'hA000_0012);
    chk("R6 status after write+trap", {32'h0, psw_o}, 64'hA000_0000);
  endtask

  task automatic t_dbg_trap;
    logic [31:0] d;
    set_psw(32'hF000_0F1D);
    do_commit(0, 2'd2);
    rd(15, d); chk("R7 saved debug status", {32'h0, d}, 64'hF000_0F1D);
    chk("R7 status DS only", {32'h0, psw_o}, 64'h1000_0000);
    set_psw(32'h0000_0F1D);
    do_commit(0, 2'd3);
    chk("R7 code 3 no trap", {32'h0, psw_o}, 64'h0000_0F1D);
    chk("R8 no swap on code 3", {63'h0, last_swap}, 64'h0);
  endtask

  task automatic t_swap;
    q32(4'd2, 32'hFFFF_FFFF, 32'h5);
    do_commit(0, 0);
    chk("R8 no swap for plain reg", {63'h0, last_swap}, 64'h0);
    q32(4'd13, 32'h0, 32'hFFFF_FFFF);
    do_commit(0, 0);
    chk("R8 swap for zero-mask psw write", {63'h0, last_swap}, 64'h1);
    @(negedge clk_i);
    chk("R8 swap one cycle", {63'h0, swap_req_o}, 64'h0);
  endtask

  task automatic t_queue;
    logic [31:0] d; logic [31:0] p; logic [63:0] a;
    for (int i = 0; i < 5; i++) q32(i[3:0], 32'hFFFF_FFFF, 32'hC0DE_0000 + i);
    q64(0, 64'h1); q64(1, 64'h2); q64(0, 64'h3);
    do_commit(0, 0);
    rd(3, d); chk("R9 fourth entry applied", {32'h0, d}, 64'hC0DE_0003);
    rd(4, d); chk("R9 fifth entry dropped", {32'h0, d}, 64'h0);
    rdacc(0, a); chk("R9 third acc entry dropped", a, 64'h1);
    p = psw_o;
    do_commit(0, 0);
    rd(0, d); chk("R9 empty commit r0", {32'h0, d}, 64'hC0DE_0000);
    chk("R9 empty commit psw", {32'h0, psw_o}, {32'h0, p});
    chk("R9 empty commit no swap", {63'h0, last_swap}, 64'h0);
    @(negedge clk_i);
    enq32_i = 1; enq32_idx_i = 4'd6; enq32_mask_i = '1; enq32_val_i = 32'hDEAD;
    commit_i = 1;
    @(negedge clk_i);
    enq32_i = 0; commit_i = 0;
    do_commit(0, 0);
    rd(6, d); chk("R9 enqueue during commit dropped", {32'h0, d}, 64'h0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_merge;
    t_order;
    t_flag_arb;
    t_va;
    t_lkr;
    t_ord_trap;
    t_dbg_trap;
    t_swap;
    t_queue;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule